// File: doc/BRIEF.md
# Transmit Buffer Descriptor Ring Engine

This block walks a ring of transmit buffer descriptors held in system memory. It collects the data each descriptor points to and sends that data out as a framed byte stream. Software fills descriptors, marks them ready and pulses a kick. The engine then reads descriptors one after another through a simple request/acknowledge memory port. For each one it streams the buffer bytes, writes the descriptor back with its ready flag cleared, and pulses per-buffer and per-frame events. It stops at the first descriptor that is not ready and keeps its position for the next kick.

Each descriptor is two 32-bit words. The first word holds a 16-bit flag field and a 16-bit length. The second holds a byte-address buffer pointer. A frame can span several descriptors, and the last one carries an end-of-frame flag. Bytes beyond the frame size limit are dropped, and an overrun event is raised.

Top module: `txbd_ring_engine`

## Requirements
- R1: Descriptor word at offset 0 carries flags in bits 31:16 and the byte length in bits 15:0. The word at offset 4 is the buffer pointer. Memory is big-endian within a word: the byte at address a sits in bits 31-8*(a mod 4) down to 24-8*(a mod 4) of the word at a with its two low bits cleared.
- R2: Flag bit 15 marks a descriptor as ready. The walk ends at the first descriptor read with bit 15 clear. No write-back, event or byte is produced for that descriptor.
- R3: Each consumed descriptor has its first word written back with bit 15 cleared and all other bits unchanged. Each consumed descriptor also gives one `ev_buf_done` pulse.
- R4: Flag bit 11 marks the last buffer of a frame. After that descriptor's bytes, `out_eof` pulses once with `out_valid` low, and `ev_frame_done` pulses in the same cycle.
- R5: Flag bit 13 (wrap) sends the next descriptor fetch to the ring base. Without it, the next descriptor is 8 bytes further on.
- R6: A frame carries at most 2032 bytes. Bytes past that are dropped, and `ev_babble` pulses once for that frame.
- R7: A kick while `ctl_enable` is low has no effect: no memory access, no output and `busy` stays low.
- R8: Loading the ring base forces its two low bits to zero and moves the current descriptor pointer to that base.
- R9: The descriptor pointer and the partial frame length are kept between walks, so a later kick resumes at the descriptor where the previous walk stopped.
- R10: `busy` is high from the cycle after an enabled kick until the walk ends. Any number of kicks during a walk cause exactly one further walk.
- R11: Bytes leave in buffer order, one per `out_valid` cycle. `out_sof` marks the first byte of each frame.
- R12: Memory addresses are word aligned. A request holds its address, direction and write data stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Controller enable; gates kicks |
| tx_kick | input | 1 | Start-walk pulse |
| ring_base_we | input | 1 | Load ring base and current pointer |
| ring_base_in | input | 32 | Ring base byte address |
| busy | output | 1 | Walk running or pending |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Frame end marker pulse |
| ev_buf_done | output | 1 | Descriptor consumed pulse |
| ev_frame_done | output | 1 | Frame completed pulse |
| ev_babble | output | 1 | Frame overrun pulse |

## Verification
On every cycle, the assertions check that memory requests stay aligned and stable until acknowledged. They also check that write-backs never carry a set ready bit, that the frame byte count never passes its limit, that a not-ready descriptor ends the walk, and that pointer loads and kicks produce the expected state. Only the bench scenarios show the full gather result: byte order, start and end marks, wrap-around, resumption across kicks, coalescing of repeated kicks, and the single overrun event. The bench compares these against a reference walk of its own copy of memory.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
    localparam int ADDR_W     = 32;
    localparam int FLAG_READY = 15;
    localparam int FLAG_WRAP  = 13;
    localparam int FLAG_LAST  = 11;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
    } desc_head_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_PTR,
        ST_DATA,
        ST_WBACK
    } walk_state_t;

    function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] lane);
        return w[8*(3-int'(lane)) +: 8];
    endfunction

    function automatic logic [ADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a & ~ADDR_W'(3);
    endfunction
endpackage

// File: rtl/txbd_kick_ctrl.sv
module txbd_kick_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    input  logic enable,
    input  logic idle,
    output logic start,
    output logic busy
);
    logic pending;

    assign start = pending & idle;
    assign busy  = pending | ~idle;

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= (pending & ~start) | (kick & enable);
    end

    a_r10_busy_after_kick: assert property (@(posedge clk) disable iff (rst)
        (kick && enable) |=> busy);
    a_r7_no_spurious_pending: assert property (@(posedge clk) disable iff (rst)
        (!pending && !(kick && enable)) |=> !pending);
endmodule

// File: rtl/txbd_desc_ptr.sv
module txbd_desc_ptr #(
    parameter int AW          = 32,
    parameter int DESC_STRIDE = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          base_we,
    input  logic [AW-1:0] base_in,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] cur
);
    logic [AW-1:0] base;
    localparam logic [AW-1:0] STEP = AW'(DESC_STRIDE);

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            cur  <= '0;
        end else if (base_we) begin
            base <= base_in & ~AW'(3);
            cur  <= base_in & ~AW'(3);
        end else if (advance) begin
            cur <= wrap ? base : cur + STEP;
        end
    end

    a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
        (cur[1:0] == 2'b00) && (base[1:0] == 2'b00));
    a_r8_load_sets_cur: assert property (@(posedge clk) disable iff (rst)
        base_we |=> (cur[AW-1:2] == $past(base_in[AW-1:2])));
    a_r5_wrap_to_base: assert property (@(posedge clk) disable iff (rst)
        (advance && wrap && !base_we) |=> (cur == base));
endmodule

// File: rtl/txbd_frame_len.sv
module txbd_frame_len #(
    parameter int MAX_FRAME = 2032
) (
    input  logic clk,
    input  logic rst,
    input  logic count_byte,
    input  logic mark_babble,
    input  logic frame_end,
    output logic first,
    output logic full,
    output logic babbled
);
    localparam int CW = $clog2(MAX_FRAME + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_FRAME);
    logic [CW-1:0] cnt;

    assign first = (cnt == '0);
    assign full  = (cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            babbled <= 1'b0;
        end else if (frame_end) begin
            cnt     <= '0;
            babbled <= 1'b0;
        end else begin
            if (count_byte) cnt <= cnt + 1'b1;
            if (mark_babble) babbled <= 1'b1;
        end
    end

    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);
    a_r6_no_count_when_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !count_byte);
    a_r6_babble_once: assert property (@(posedge clk) disable iff (rst)
        babbled |-> !mark_babble);
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine
    import txbd_pkg::*;
#(
    parameter int MAX_FRAME   = 2032,
    parameter int DESC_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_enable,
    input  logic              tx_kick,
    input  logic              ring_base_we,
    input  logic [ADDR_W-1:0] ring_base_in,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              ev_buf_done,
    output logic              ev_frame_done,
    output logic              ev_babble
);
    walk_state_t       state;
    desc_head_t        head;
    logic [ADDR_W-1:0] bptr;
    logic [15:0]       rem;
    logic [ADDR_W-1:0] cur;
    logic              start, idle;
    logic              f_first, f_full, f_babbled;
    logic              count_byte, mark_babble, frame_end, advance;
    logic              data_read;

    assign idle = (state == ST_IDLE);

    txbd_kick_ctrl u_kick (
        .clk(clk), .rst(rst), .kick(tx_kick), .enable(ctl_enable),
        .idle(idle), .start(start), .busy(busy)
    );

    txbd_desc_ptr #(.AW(ADDR_W), .DESC_STRIDE(DESC_STRIDE)) u_ptr (
        .clk(clk), .rst(rst), .base_we(ring_base_we), .base_in(ring_base_in),
        .advance(advance), .wrap(head.flags[FLAG_WRAP]), .cur(cur)
    );

    txbd_frame_len #(.MAX_FRAME(MAX_FRAME)) u_len (
        .clk(clk), .rst(rst), .count_byte(count_byte), .mark_babble(mark_babble),
        .frame_end(frame_end), .first(f_first), .full(f_full), .babbled(f_babbled)
    );

    assign data_read   = (state == ST_DATA) && (rem != '0) && !f_full;
    assign count_byte  = data_read && mem_ack;
    assign mark_babble = (state == ST_DATA) && (rem != '0) && f_full && !f_babbled;
    assign advance     = (state == ST_WBACK) && mem_ack;
    assign frame_end   = advance && head.flags[FLAG_LAST];

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = {head.flags & ~(16'(1) << FLAG_READY), head.len};
        unique case (state)
            ST_HEAD:  mem_req = 1'b1;
            ST_PTR: begin
                mem_req  = 1'b1;
                mem_addr = cur + ADDR_W'(4);
            end
            ST_DATA: begin
                mem_req  = data_read;
                mem_addr = word_of(bptr);
            end
            ST_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            head          <= '0;
            bptr          <= '0;
            rem           <= '0;
            out_valid     <= 1'b0;
            out_data      <= '0;
            out_sof       <= 1'b0;
            out_eof       <= 1'b0;
            ev_buf_done   <= 1'b0;
            ev_frame_done <= 1'b0;
            ev_babble     <= 1'b0;
        end else begin
            out_valid     <= 1'b0;
            out_sof       <= 1'b0;
            out_eof       <= 1'b0;
            ev_buf_done   <= 1'b0;
            ev_frame_done <= 1'b0;
            ev_babble     <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) state <= ST_HEAD;
                ST_HEAD: if (mem_ack) begin
                    head  <= desc_head_t'(mem_rdata);
                    state <= mem_rdata[16+FLAG_READY] ? ST_PTR : ST_IDLE;
                end
                ST_PTR: if (mem_ack) begin
                    bptr  <= mem_rdata;
                    rem   <= head.len;
                    state <= ST_DATA;
                end
                ST_DATA: begin
                    if (rem == '0) begin
                        state <= ST_WBACK;
                    end else if (f_full) begin
                        ev_babble <= mark_babble;
                        rem       <= '0;
                        state     <= ST_WBACK;
                    end else if (mem_ack) begin
                        out_valid <= 1'b1;
                        out_data  <= pick_byte(mem_rdata, bptr[1:0]);
                        out_sof   <= f_first;
                        bptr      <= bptr + 1'b1;
                        rem       <= rem - 1'b1;
                    end
                end
                ST_WBACK: if (mem_ack) begin
                    ev_buf_done   <= 1'b1;
                    ev_frame_done <= head.flags[FLAG_LAST];
                    out_eof       <= head.flags[FLAG_LAST];
                    state         <= ST_HEAD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r12_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    a_r12_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    a_r3_wback_not_ready: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[16+FLAG_READY]);
    a_r2_stop_on_not_ready: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HEAD && mem_ack && !mem_rdata[16+FLAG_READY]) |=> (!mem_req && !ev_buf_done));
    a_r11_sof_on_byte: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_valid);
    a_r4_eof_alone: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> !out_valid);
endmodule

// File: tb/txbd_ring_engine_tb_top.sv
module txbd_ring_engine_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        ctl_enable = 0, tx_kick = 0, ring_base_we = 0;
    logic [31:0] ring_base_in = '0;
    logic        busy, mem_req, mem_we, mem_ack = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        out_valid, out_sof, out_eof, ev_buf_done, ev_frame_done, ev_babble;
    logic [7:0]  out_data;

    always #4 clk = ~clk;

    txbd_ring_engine dut_i (.*);

    logic [31:0] mem  [0:2047];
    logic [31:0] smem [0:2047];

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[12:2]];
            if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    int errors = 0, checks = 0;
    int act_q[$], exp_q[$];
    int a_buf = 0, a_frm = 0, a_bab = 0, e_buf = 0, e_frm = 0, e_bab = 0;
    int watch_addr = -1, watch_reads = 0, any_req = 0;
    int cycles = 0;
    logic [31:0] m_base = 0, m_cur = 0;
    int m_fcnt = 0, m_bab = 0;

    always @(negedge clk) begin
        if (out_valid) act_q.push_back(int'(out_data) + (out_sof ? 256 : 0));
        if (out_eof) act_q.push_back(512);
        if (ev_buf_done) a_buf++;
        if (ev_frame_done) a_frm++;
        if (ev_babble) a_bab++;
        if (mem_req) any_req++;
        if (mem_req && mem_ack && !mem_we && int'(mem_addr) == watch_addr) watch_reads++;
        cycles++;
        if (cycles > 190000) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish (act %0d exp %0d)", cycles, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rd_byte(input logic [31:0] a);
        logic [31:0] w = smem[a[12:2]];
        return int'(w[8*(3-int'(a[1:0])) +: 8]);
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [15:0] fl, input logic [15:0] ln, input logic [31:0] p);
        mem[a[12:2]] = {fl, ln}; smem[a[12:2]] = {fl, ln};
        mem[a[12:2]+1] = p;      smem[a[12:2]+1] = p;
    endtask

    // Reference walk over the shadow memory (R1..R6, R9, R11)
    task automatic model_walk();
        for (int guard = 0; guard < 2000; guard++) begin
            logic [31:0] w0 = smem[m_cur[12:2]];
            logic [31:0] p  = smem[m_cur[12:2]+1];
            if (!w0[31]) break;
            for (int i = 0; i < int'(w0[15:0]); i++) begin
                if (m_fcnt >= 2032) begin
                    if (!m_bab) begin e_bab++; m_bab = 1; end
                    break;
                end
                exp_q.push_back(rd_byte(p + 32'(i)) + (m_fcnt == 0 ? 256 : 0));
                m_fcnt++;
            end
            e_buf++;
            smem[m_cur[12:2]] = w0 & ~32'h8000_0000;
            if (w0[27]) begin exp_q.push_back(512); e_frm++; m_fcnt = 0; m_bab = 0; end
            m_cur = w0[29] ? m_base : m_cur + 8;
        end
    endtask

    task automatic load_base(input logic [31:0] a);
        @(negedge clk); ring_base_we = 1; ring_base_in = a;
        @(negedge clk); ring_base_we = 0;
        m_base = a & ~32'd3; m_cur = m_base;
    endtask

    task automatic kick();
        @(negedge clk); tx_kick = 1;
        @(negedge clk); tx_kick = 0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        repeat (3) @(negedge clk);
        while (quiet < 4) begin
            @(negedge clk);
            if (busy) quiet = 0; else quiet++;
        end
    endtask

    task automatic compare(input string tag);
        int bad = -1;
        check(act_q.size() == exp_q.size(), {tag, " R11 stream length"}, act_q.size(), exp_q.size());
        foreach (exp_q[i]) if (bad < 0 && i < act_q.size() && act_q[i] != exp_q[i]) bad = i;
        check(bad < 0, {tag, " R11/R1 stream content"}, bad < 0 ? 0 : act_q[bad], bad < 0 ? 0 : exp_q[bad]);
        check(a_buf == e_buf, {tag, " R3 buffer events"}, a_buf, e_buf);
        check(a_frm == e_frm, {tag, " R4 frame events"}, a_frm, e_frm);
        check(a_bab == e_bab, {tag, " R6 babble events"}, a_bab, e_bab);
        begin
            int mm = 0;
            for (int i = 0; i < 128; i++) if (mem[i] !== smem[i]) mm++;
            check(mm == 0, {tag, " R3/R5 descriptor write-back"}, mm, 0);
        end
        act_q.delete(); exp_q.delete();
        a_buf = 0; a_frm = 0; a_bab = 0; e_buf = 0; e_frm = 0; e_bab = 0;
    endtask

    initial begin
        process::self().srandom(32'h5eed_1234);
        for (int i = 0; i < 2048; i++) begin
            logic [31:0] v = $urandom;
            mem[i] = (i < 128) ? 32'd0 : v;
            smem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(!busy && !mem_req && !out_valid, "reset R10/R12 idle outputs", int'({busy, mem_req, out_valid}), 0);

        ctl_enable = 1;
        // Directed: two-buffer frame, empty last buffer, then not-ready stop (R1-R4, R11)
        put_desc(32'h00, 16'h8000, 16'd5, 32'h0401);
        put_desc(32'h08, 16'h8800, 16'd3, 32'h0503);
        put_desc(32'h10, 16'h8800, 16'd0, 32'h0600);
        put_desc(32'h18, 16'h0000, 16'd4, 32'h0700);
        load_base(32'h0);
        model_walk(); kick(); wait_idle();
        compare("directed");
        check(mem[6][31] == 1'b0, "R2 not-ready descriptor untouched flags", int'(mem[6][31:16]), 0);

        // Resume at stopped descriptor, wrap back to base (R9, R5)
        put_desc(32'h18, 16'hA800, 16'd4, 32'h0702);
        put_desc(32'h00, 16'h8800, 16'd2, 32'h0410);
        put_desc(32'h08, 16'h0000, 16'd0, 32'h0);
        model_walk(); kick(); wait_idle();
        compare("resume-wrap R9 R5");

        // Kick while disabled is ignored (R7)
        put_desc(32'h08, 16'h8800, 16'd3, 32'h0420);
        ctl_enable = 0;
        any_req = 0;
        kick();
        repeat (20) @(negedge clk);
        check(any_req == 0 && act_q.size() == 0 && !busy, "R7 disabled kick ignored", any_req + act_q.size(), 0);
        check(mem[2][31] == 1'b1, "R7 descriptor still ready", int'(mem[2][31]), 1);
        ctl_enable = 1;
        model_walk(); kick(); wait_idle();
        compare("after-enable R7");

        // Unaligned base load (R8)
        put_desc(32'h40, 16'h8800, 16'd6, 32'h0803);
        put_desc(32'h48, 16'h0000, 16'd0, 32'h0);
        load_base(32'h43);
        model_walk(); kick(); wait_idle();
        compare("base-load R8");

        // Repeated kicks during a walk coalesce into one extra walk (R10)
        put_desc(32'h40, 16'h8000, 16'd20, 32'h0900);
        put_desc(32'h48, 16'h8800, 16'd20, 32'h0A00);
        put_desc(32'h50, 16'h0000, 16'd0, 32'h0);
        load_base(32'h40);
        watch_addr = 32'h50; watch_reads = 0;
        model_walk();
        kick();
        check(busy == 1'b1, "R10 busy after kick", int'(busy), 1);
        repeat (5) @(negedge clk);
        kick(); kick(); kick();
        wait_idle();
        check(watch_reads == 2, "R10 pending kicks coalesced", watch_reads, 2);
        compare("pending R10");
        watch_addr = -1;

        // Frame overrun (R6) then a fresh frame
        put_desc(32'h60, 16'h8000, 16'd900, 32'h0800);
        put_desc(32'h68, 16'h8000, 16'd900, 32'h1000);
        put_desc(32'h70, 16'h8800, 16'd900, 32'h1800);
        put_desc(32'h78, 16'h8800, 16'd10, 32'h1C01);
        put_desc(32'h80, 16'h0000, 16'd0, 32'h0);
        load_base(32'h60);
        model_walk(); kick(); wait_idle();
        compare("babble R6");

        // Constrained random rings
        for (int r = 0; r < 24; r++) begin
            int n = 2 + int'($urandom % 7);
            for (int d = 0; d < n; d++) begin
                logic [15:0] fl = 16'h0;
                if (($urandom % 8) != 0) fl[15] = 1'b1;
                if (($urandom % 2) != 0) fl[11] = 1'b1;
                if (d == n - 1) fl[13] = 1'b1;
                put_desc(32'h100 + 32'(8*d), fl, 16'($urandom % 25), 32'h400 + 32'($urandom % 32'h1A00));
            end
            load_base(32'h100 + 32'($urandom % 4));
            model_walk(); kick(); wait_idle();
            compare($sformatf("random %0d R5 R9", r));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule